// File: doc/BRIEF.md
# Four-Channel Block DMA Engine

This block moves data in fixed 32-byte blocks on behalf of up to four independent channels. Software sets up each channel through a 32-bit register port with a start address on each side, a block count and a control word. The control word picks how each address moves between blocks, holds the enable bit and the interrupt-enable bit, and holds a sticky completion flag. A shared operation register acts as the master switch for the whole engine.

A channel runs when it is armed, its completion flag is clear, it still has blocks to move, its device request line is high, and the engine is switched on. For each block the engine reads 32 bytes from the current source address on its master port, then writes the same 32 bytes to the current destination address. After that it steps both addresses and decrements the count. When the count reaches zero the completion flag sets and stays set until software clears it. The channel's interrupt line is raised while the flag and the interrupt enable are both set. Arbitration between channels happens again before every block.

Top module: `bdma_top`

## Requirements
- R1: Channel c owns four registers at byte offset 16*c: source address at +0x0, destination address at +0x4, block count at +0x8 and a 16-bit control word at +0xC. Bit 3 of the control word always reads 0, and bits 31:16 read 0. A 16-bit operation register sits at 0x40. A read returns its data on reg_rdata at the clock edge that samples reg_re. Unmapped addresses read 0.
- R2: No block is started while bit 0 of the operation register is clear. Writing 0x8201 switches the engine on.
- R3: A channel is eligible only when control bit 0 (enable) is 1, control bit 1 (done) is 0, its count is nonzero and dev_req[c] is high.
- R4: Each finished block decrements the count by 1. When the count reaches 0, control bit 1 becomes 1 and every other control bit keeps its value, so 0x12C1 becomes 0x12C3 and 0x43C1 becomes 0x43C3.
- R5: Control bits [13:12] step the source address and bits [15:14] step the destination address after each block: 00 holds, 01 adds 32, 10 subtracts 32, 11 holds.
- R6: Each block is a master read at the source address followed by a master write of the returned 256 bits to the destination address. mem_req stays high, with its address and direction unchanged, until mem_ack.
- R7: irq[c] is high exactly when control bits 1 and 2 of channel c are both 1.
- R8: Among eligible channels the lowest index wins. The choice is made again before every block, so a lower channel finishes before a higher one starts.
- R9: Writing the control word with bit 1 clear and bit 0 set re-arms a finished channel once its count has been reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dev_req | input | 4 | Per-channel device request level |
| irq | output | 4 | Per-channel interrupt |
| mem_req | output | 1 | Master block request |
| mem_we | output | 1 | 1 = block write, 0 = block read |
| mem_addr | output | 32 | Block byte address |
| mem_wdata | output | 256 | Block write data |
| mem_rdata | input | 256 | Block read data |
| mem_ack | input | 1 | Request accepted / read data valid |

## Verification
The bench builds the engine with its default four channels and 32-byte block size. It sweeps every channel through block counts of one to four in both directions: memory to a fixed device address, and a fixed device address to incrementing memory. With four channels, fixed-priority starvation between two channels that start together can be tested, as can each gating condition in isolation. The decrementing address mode, the sticky done flag with re-arm, and the interrupt mask are each tested on a chosen channel.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  typedef enum logic [1:0] {MV_IDLE, MV_RD, MV_WR, MV_DONE} mv_state_e;

  localparam logic [1:0] STEP_HOLD = 2'b00;
  localparam logic [1:0] STEP_UP   = 2'b01;
  localparam logic [1:0] STEP_DOWN = 2'b10;

  localparam int CTL_EN   = 0;
  localparam int CTL_DONE = 1;
  localparam int CTL_IE   = 2;
  localparam int CTL_RSVD = 3;
  localparam int CTL_SRC_LO = 12;
  localparam int CTL_DST_LO = 14;
endpackage

// File: rtl/bdma_chan.sv
module bdma_chan
  import bdma_pkg::*;
#(
  parameter int AW  = 32,
  parameter int BLK = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          blk_done,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [31:0]   cnt_q,
  output logic [15:0]   ctl_q,
  output logic          ready,
  output logic          irq
);
  localparam logic [AW-1:0] STEP = AW'(BLK);
  localparam logic [15:0] CTL_MASK = ~(16'(1) << CTL_RSVD);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic [1:0] m);
    case (m)
      STEP_UP:   return a + STEP;
      STEP_DOWN: return a - STEP;
      default:   return a;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_en) begin
        case (wr_sel)
          2'd0: src_q <= wr_data[AW-1:0];
          2'd1: dst_q <= wr_data[AW-1:0];
          2'd2: cnt_q <= wr_data;
          default: ctl_q <= wr_data[15:0] & CTL_MASK;
        endcase
      end
      // engine update takes precedence over a same-cycle software write
      if (blk_done) begin
        src_q <= step_addr(src_q, ctl_q[CTL_SRC_LO+1:CTL_SRC_LO]);
        dst_q <= step_addr(dst_q, ctl_q[CTL_DST_LO+1:CTL_DST_LO]);
        cnt_q <= cnt_q - 32'd1;
        if (cnt_q == 32'd1) ctl_q[CTL_DONE] <= 1'b1;
      end
    end
  end

  assign ready = ctl_q[CTL_EN] & ~ctl_q[CTL_DONE] & (cnt_q != 32'd0);
  assign irq   = ctl_q[CTL_DONE] & ctl_q[CTL_IE];

  // R4: a block never finishes on an empty channel
  assert_cnt_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    blk_done |-> cnt_q != 32'd0);

  // R4: done flag sets by hardware only when the count has run out
  assert_done_at_end_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(ctl_q[CTL_DONE]) && !$past(wr_en && wr_sel == 2'd3)) |-> cnt_q == 32'd0);

  // R5: incrementing source moves by one block
  assert_src_step_R5: assert property (@(posedge clk) disable iff (rst)
    (blk_done && ctl_q[CTL_SRC_LO+1:CTL_SRC_LO] == STEP_UP) |=> src_q == $past(src_q) + STEP);
endmodule

// File: rtl/bdma_arb.sv
module bdma_arb #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  // R8: the winner requests and nobody below it does
  assert_low_wins_R8: assert property (@(posedge clk) disable iff (rst)
    any |-> (req[idx] && ((req & ((N'(1) << idx) - N'(1))) == '0)));
endmodule

// File: rtl/bdma_mover.sv
module bdma_mover
  import bdma_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 32,
  parameter int DW = 256,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [IW-1:0]         start_idx,
  input  logic [N-1:0][AW-1:0]  src_all,
  input  logic [N-1:0][AW-1:0]  dst_all,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [DW-1:0]         mem_wdata,
  input  logic [DW-1:0]         mem_rdata,
  input  logic                  mem_ack,
  output logic [N-1:0]          blk_done,
  output logic                  busy
);
  mv_state_e     st;
  logic [IW-1:0] cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= MV_IDLE;
      cur       <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      case (st)
        MV_IDLE: if (start) begin
          cur      <= start_idx;
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= src_all[start_idx];
          st       <= MV_RD;
        end
        MV_RD: if (mem_ack) begin
          mem_we    <= 1'b1;
          mem_addr  <= dst_all[cur];
          mem_wdata <= mem_rdata;
          st        <= MV_WR;
        end
        MV_WR: if (mem_ack) begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          st      <= MV_DONE;
        end
        default: st <= MV_IDLE;
      endcase
    end
  end

  always_comb begin
    blk_done = '0;
    if (st == MV_DONE) blk_done[cur] = 1'b1;
  end
  assign busy = (st != MV_IDLE);

  // R6: a pending request holds still until accepted
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R6: at most one channel is credited per block
  assert_one_done_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(blk_done));
endmodule

// File: rtl/bdma_top.sv
module bdma_top #(
  parameter int N   = 4,
  parameter int AW  = 32,
  parameter int BLK = 32,
  parameter int RA_W = $clog2(N * 16) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [N-1:0]      dev_req,
  output logic [N-1:0]      irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BLK*8-1:0]  mem_wdata,
  input  logic [BLK*8-1:0]  mem_rdata,
  input  logic              mem_ack
);
  localparam int DW  = BLK * 8;
  localparam int IW  = (N > 1) ? $clog2(N) : 1;
  localparam int CHB = (N > 1) ? $clog2(N) : 1;
  localparam logic [RA_W-1:0] OP_ADDR = RA_W'(N * 16);

  logic [15:0]               op_q;
  logic                      glob_en;
  logic [N-1:0][AW-1:0]      src_all, dst_all;
  logic [N-1:0][31:0]        cnt_all;
  logic [N-1:0][15:0]        ctl_all;
  logic [N-1:0]              ready, elig, blk_done;
  logic                      in_chan, any;
  logic [IW-1:0]             gidx;
  logic [CHB-1:0]            ch_sel;
  logic                      busy;

  assign in_chan = reg_addr < OP_ADDR;
  assign ch_sel  = reg_addr[CHB+3:4];
  assign glob_en = op_q[0];

  always_ff @(posedge clk) begin
    if (rst) op_q <= '0;
    else if (reg_we && reg_addr == OP_ADDR) op_q <= reg_wdata[15:0];
  end

  for (genvar c = 0; c < N; c++) begin : g_ch
    bdma_chan #(.AW(AW), .BLK(BLK)) u_ch (
      .clk(clk), .rst(rst),
      .wr_en(reg_we && in_chan && ch_sel == CHB'(c)),
      .wr_sel(reg_addr[3:2]), .wr_data(reg_wdata),
      .blk_done(blk_done[c]),
      .src_q(src_all[c]), .dst_q(dst_all[c]), .cnt_q(cnt_all[c]), .ctl_q(ctl_all[c]),
      .ready(ready[c]), .irq(irq[c])
    );
  end

  assign elig = ready & dev_req & {N{glob_en}};

  bdma_arb #(.N(N), .IW(IW)) u_arb (
    .clk(clk), .rst(rst), .req(elig), .any(any), .idx(gidx)
  );

  bdma_mover #(.N(N), .AW(AW), .DW(DW), .IW(IW)) u_mv (
    .clk(clk), .rst(rst), .start(any), .start_idx(gidx),
    .src_all(src_all), .dst_all(dst_all),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .blk_done(blk_done), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_re) begin
      if (reg_addr == OP_ADDR) reg_rdata <= {16'b0, op_q};
      else if (in_chan) begin
        case (reg_addr[3:2])
          2'd0: reg_rdata <= 32'(src_all[ch_sel]);
          2'd1: reg_rdata <= 32'(dst_all[ch_sel]);
          2'd2: reg_rdata <= cnt_all[ch_sel];
          default: reg_rdata <= {16'b0, ctl_all[ch_sel]};
        endcase
      end else reg_rdata <= '0;
    end
  end

  // R2: a block only begins if the engine was switched on
  assert_start_gated_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(glob_en));

  // R3: the master port is quiet while no block is in flight
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);
endmodule

// File: tb/tb_bdma_top.sv
module tb_bdma_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 0, rst = 1;
  logic reg_we = 0, reg_re = 0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] dev_req = '0, irq;
  logic mem_req, mem_we, mem_ack = 0;
  logic [31:0] mem_addr;
  logic [255:0] mem_wdata, mem_rdata = '0;

  int nchk = 0, nfail = 0;
  int dev_wr_cnt = 0;
  logic [31:0] dev_last_addr = '0;
  logic [255:0] dev_last_data = '0;
  logic [255:0] mem [0:63];

  bdma_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [255:0] pat(input int i);
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = 32'hC0DE0000 ^ (32'(i) << 8) ^ 32'(k);
    return v;
  endfunction

  function automatic logic [255:0] dpat(input logic [31:0] a);
    return {8{a ^ 32'h5A5A5A5A}};
  endfunction

  // memory below 0x800, device space above
  initial begin
    for (int i = 0; i < 64; i++) mem[i] = pat(i);
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 0;
      else if (mem_req) begin
        if (mem_we) begin
          if (mem_addr < 32'h800) mem[mem_addr[10:5]] = mem_wdata;
          else begin
            dev_wr_cnt++;
            dev_last_addr = mem_addr;
            dev_last_data = mem_wdata;
          end
        end else begin
          mem_rdata = (mem_addr < 32'h800) ? mem[mem_addr[10:5]] : dpat(mem_addr);
        end
        mem_ack = 1;
      end
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = 7'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1; reg_addr = 7'(a);
    @(negedge clk);
    reg_re = 0;
    d = reg_rdata;
  endtask

  task automatic wait_done(input int ch, output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int t = 0; t < 300; t++) begin
      rd(ch*16 + 12, v);
      if (v[1]) begin ok = 1; break; end
    end
  endtask

  task automatic run_one(input int ch, input int nb, input int dir);
    logic [31:0] s, d, ctl, v;
    int dw0;
    bit ok;
    int b = ch * 16;
    if (dir == 0) begin s = 32'(ch*256); d = 32'h800 + 32'(ch*64); ctl = 32'h12C0; end
    else begin s = 32'h900 + 32'(ch*32); d = 32'h400 + 32'(ch*128); ctl = 32'h43C0; end
    wr(b+12, ctl); wr(b, s); wr(b+4, d); wr(b+8, 32'(nb));
    dw0 = dev_wr_cnt;
    wr(b+12, ctl | 32'h1);
    wait_done(ch, ok);
    chk("R4 done flag", {31'b0, ok}, 1);
    rd(b+8, v);  chk("R4 count zero", v, 0);
    rd(b+12, v); chk("R4 control", v, ctl | 32'h3);
    rd(b, v);    chk("R5 source", v, (dir == 0) ? s + 32'(32*nb) : s);
    rd(b+4, v);  chk("R5 destination", v, (dir == 0) ? d : d + 32'(32*nb));
    if (dir == 0) begin
      chk("R6 device writes", 32'(dev_wr_cnt - dw0), 32'(nb));
      chk("R6 device data", {31'b0, dev_last_data == pat(ch*8 + nb - 1)}, 1);
      chk("R5 fixed dest addr", dev_last_addr, d);
    end else begin
      for (int k = 0; k < nb; k++)
        chk("R6 memory data", {31'b0, mem[d[10:5] + k] == dpat(s)}, 1);
    end
    chk("R7 irq masked", {31'b0, irq[ch]}, 0);
    wr(b+12, 0);
  endtask

  initial begin
    logic [31:0] v;
    bit ok;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    for (int c = 0; c < N; c++)
      for (int r = 0; r < 4; r++) begin rd(c*16 + r*4, v); chk("R1 reset value", v, 0); end
    rd(64, v); chk("R1 reset op", v, 0);
    chk("R7 irq reset", {28'b0, irq}, 0);

    // R1 readback, reserved bit, unmapped
    for (int c = 0; c < N; c++) begin
      wr(c*16, 32'h1000 + 32'(c)); wr(c*16+4, 32'hABCD0000 + 32'(c));
      wr(c*16+8, 32'h77 + 32'(c)); wr(c*16+12, 32'hFFFFFFFF);
      rd(c*16, v);    chk("R1 src readback", v, 32'h1000 + 32'(c));
      rd(c*16+4, v);  chk("R1 dst readback", v, 32'hABCD0000 + 32'(c));
      rd(c*16+8, v);  chk("R1 cnt readback", v, 32'h77 + 32'(c));
      rd(c*16+12, v); chk("R1 ctl readback", v, 32'hFFF7);
      wr(c*16+12, 0); wr(c*16+8, 0);
    end
    rd(68, v); chk("R1 unmapped", v, 0);

    // R2 engine off: nothing moves
    dev_req = '1;
    wr(12, 32'h12C0); wr(0, 0); wr(4, 32'h800); wr(8, 2); wr(12, 32'h12C1);
    repeat (40) @(negedge clk);
    rd(8, v); chk("R2 held while off", v, 2);
    chk("R2 no request", {31'b0, mem_req}, 0);
    wr(64, 32'h8201);
    rd(64, v); chk("R2 op readback", v, 32'h8201);
    wait_done(0, ok); chk("R2 runs when on", {31'b0, ok}, 1);
    rd(12, v); chk("R4 0x12C3", v, 32'h12C3);

    // R3 done flag blocks restart; R9 re-arm
    wr(8, 2);
    repeat (40) @(negedge clk);
    rd(8, v); chk("R3 done flag blocks", v, 2);
    wr(12, 32'h12C1);
    wait_done(0, ok); chk("R9 re-armed", {31'b0, ok}, 1);
    rd(8, v); chk("R9 count drained", v, 0);
    wr(12, 0);

    // R3 enable clear; request low
    wr(16+12, 32'h12C0); wr(16, 0); wr(16+4, 32'h800); wr(16+8, 1);
    repeat (30) @(negedge clk);
    rd(16+8, v); chk("R3 enable clear", v, 1);
    dev_req = 4'b1101;
    wr(16+12, 32'h12C1);
    repeat (30) @(negedge clk);
    rd(16+8, v); chk("R3 request low", v, 1);
    dev_req = '1;
    wait_done(1, ok); chk("R3 request high", {31'b0, ok}, 1);
    wr(16+12, 0);

    // sweep all channels, counts, directions (R4 R5 R6)
    for (int c = 0; c < N; c++)
      for (int nb = 1; nb <= 4; nb++)
        for (int dir = 0; dir < 2; dir++) run_one(c, nb, dir);

    // R7 interrupt enabled
    wr(48+12, 32'h12C4); wr(48, 0); wr(48+4, 32'h800); wr(48+8, 1);
    chk("R7 irq idle", {31'b0, irq[3]}, 0);
    wr(48+12, 32'h12C5);
    wait_done(3, ok);
    chk("R7 irq raised", {31'b0, irq[3]}, 1);
    rd(48+12, v); chk("R7 control", v, 32'h12C7);
    wr(48+12, 0);
    chk("R7 irq cleared", {31'b0, irq[3]}, 0);

    // R5 decrementing destination
    wr(32+12, 32'h83C0); wr(32, 32'h940); wr(32+4, 32'h5E0); wr(32+8, 2);
    wr(32+12, 32'h83C1);
    wait_done(2, ok);
    rd(32+4, v); chk("R5 decrement", v, 32'h5A0);
    chk("R6 dec block0", {31'b0, mem[6'h2F] == dpat(32'h940)}, 1);
    chk("R6 dec block1", {31'b0, mem[6'h2E] == dpat(32'h940)}, 1);
    wr(32+12, 0);

    // R8 fixed priority: ch1 beats ch2
    wr(64, 0);
    wr(16+12, 32'h12C4); wr(16, 0); wr(16+4, 32'h800); wr(16+8, 4); wr(16+12, 32'h12C5);
    wr(32+12, 32'h12C0); wr(32, 32'h100); wr(32+4, 32'h820); wr(32+8, 4); wr(32+12, 32'h12C1);
    wr(64, 32'h8201);
    for (int t = 0; t < 400 && !irq[1]; t++) @(negedge clk);
    chk("R8 low channel finished", {31'b0, irq[1]}, 1);
    rd(32+8, v); chk("R8 high channel waited", v, 4);
    wait_done(2, ok); chk("R8 high channel later", {31'b0, ok}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule